// File: doc/BRIEF.md
# Ethernet Transmit Bid Controller

This block accepts transmit requests from a host through a small register port and turns each one into a guarded transfer of frame bytes into a 2048-byte transmit buffer. The host first writes a command word and then a frame length. The block checks the length, reserves buffer space for the frame, and reports two status bits. One bit says that the host may now write data. The other says that the last bid was rejected.

As the host writes frame bytes, the block passes them on to the buffer and counts them. When the early-start threshold that the command word selects is reached, it sends a one-cycle start request to the MAC back end. The frame length and three per-frame control flags go out with that request. When the MAC has finished with a frame it returns the frame's space, and a waiting bid can then be granted. A force bit in the command word empties the buffer.

Top module: `txbid_ctrl`

## Requirements
- R1: A write to register address 0 stores all 16 bits of the command word, and a read of address 0 returns that value unchanged.
- R2: A length write (address 1) is accepted only when a command write has come after the previous length write. A length write with no fresh command sets the bid-error flag and grants nothing.
- R3: A length of 0 or above 1514 sets the bid-error flag (status bit 7), drops the pending command and never raises the ready flag.
- R4: A read of the status register (address 2) returns the bid-error flag in bit 7 and then clears it, so the next read shows 0.
- R5: The ready flag (status bit 8) rises only when the free space (2048 minus reserved bytes) is at least the frame length. It stays clear while space is short and rises once a release on the buffer-release inputs frees enough space.
- R6: Data bytes written to address 3 (bits 7:0) while the ready flag is clear are dropped: they produce no buffer write and are not counted toward the frame.
- R7: Command bits 7:6 select the start point: 00 starts after 5 bytes, 01 after 381, 10 after 1021, 11 after the whole frame.
- R8: When the frame is shorter than the selected threshold, the start request is raised on the frame's last byte.
- R9: The start request lasts one cycle and comes at most once per granted bid. The ready flag clears after the last byte, and the byte count restarts at zero for the next bid.
- R10: A command write with bit 8 set pulses the buffer-flush output and frees all reserved buffer space.
- R11: While the start request is high, the outputs carry the frame length and command bits 9 (no retry after collision), 12 (no CRC) and 13 (no padding).
- R12: Command and length writes made while a bid is pending or ready are ignored: the command read-back keeps its old value and no bid error is raised.
- R13: After reset the command reads 0, both status flags are 0, and no start, buffer write or flush is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 command, 1 length, 2 status, 3 data byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| buf_release | input | 1 | MAC returns buffer space of one frame |
| buf_release_len | input | 12 | Bytes returned |
| buf_wr_en | output | 1 | Frame byte write into the buffer |
| buf_wr_data | output | 8 | Frame byte |
| buf_flush | output | 1 | Discard buffer contents |
| tx_start | output | 1 | One-cycle start request to the MAC |
| tx_len | output | 12 | Frame length for the started frame |
| tx_no_retry | output | 1 | Do not retransmit after a collision |
| tx_no_crc | output | 1 | Do not append CRC |
| tx_no_pad | output | 1 | Do not pad short frames |

## Verification
The main function is tried with frames in each of the four start modes. The lengths are chosen so that the threshold is hit before the end of the frame in modes 00, 01 and 10, and the frame ends first in mode 11 and in a short mode-01 frame. This shows whether the threshold was decoded correctly or simply clipped to the length. Bids of length 0, 1515 and 1514, and a length with no command before it, tell rejected bids apart from accepted ones. A 1514-byte frame left in the buffer, followed by a 1000-byte bid, tells the space wait apart from both the release path and the force path. Bytes written with no grant check that unsolicited data is dropped.

// File: rtl/txbid_pkg.sv
// Shared register map, command and status bit positions for the transmit bid controller.
package txbid_pkg;

    typedef enum logic [1:0] {
        RA_CMD  = 2'd0,
        RA_LEN  = 2'd1,
        RA_STAT = 2'd2,
        RA_DATA = 2'd3
    } reg_addr_e;

    localparam int CMD_MODE_LO = 6;
    localparam int CMD_FORCE   = 8;
    localparam int CMD_ONECOLL = 9;
    localparam int CMD_NOCRC   = 12;
    localparam int CMD_NOPAD   = 13;

    localparam int STAT_ERR = 7;
    localparam int STAT_RDY = 8;

endpackage

// File: rtl/txbid_bid.sv
// Bid state machine: holds the command word, checks each length write, keeps the
// bid-error and ready flags, and issues a grant when the space tracker reports a fit.
// Assumes only one bid is open at a time; writes during an open bid are dropped.
module txbid_bid #(
    parameter int REG_W     = 16,
    parameter int LEN_W     = 12,
    parameter int MAX_FRAME = 1514
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             len_wr,
    input  logic             stat_rd,
    input  logic [REG_W-1:0] wdata,
    input  logic             fits,
    input  logic             last_byte,
    output logic [REG_W-1:0] cmd_q,
    output logic [LEN_W-1:0] len_q,
    output logic             ready,
    output logic             bid_err,
    output logic             grant,
    output logic             force_req
);
    logic fresh;
    logic pending;
    logic active;
    logic len_bad;

    assign active  = pending | ready;
    assign len_bad = (wdata == '0) || (wdata > REG_W'(MAX_FRAME));
    assign grant   = pending & fits;

    // Bid sequencing: command capture, length check, grant and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            len_q     <= '0;
            fresh     <= 1'b0;
            pending   <= 1'b0;
            ready     <= 1'b0;
            bid_err   <= 1'b0;
            force_req <= 1'b0;
        end else begin
            force_req <= 1'b0;
            if (stat_rd) begin
                bid_err <= 1'b0;
            end
            if (cmd_wr && !active) begin
                cmd_q     <= wdata;
                fresh     <= 1'b1;
                force_req <= wdata[txbid_pkg::CMD_FORCE];
            end
            if (len_wr && !active) begin
                fresh <= 1'b0;
                if (!fresh || len_bad) begin
                    bid_err <= 1'b1;
                end else begin
                    pending <= 1'b1;
                    len_q   <= wdata[LEN_W-1:0];
                end
            end
            if (grant) begin
                pending <= 1'b0;
                ready   <= 1'b1;
            end
            if (ready && last_byte) begin
                ready <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txbid_space.sv
// Buffer space tracker: adds a frame's length on each grant, subtracts space that
// the MAC returns (never going below zero), and clears everything on a flush.
// Assumes a grant is only given when the frame fits, so the count stays within the buffer.
module txbid_space #(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic [LEN_W-1:0] need_len,
    input  logic             release_en,
    input  logic [LEN_W-1:0] release_len,
    input  logic             flush,
    output logic [LEN_W-1:0] used,
    output logic             fits
);
    localparam int SUM_W = LEN_W + 1;

    logic [LEN_W-1:0] free_bytes;
    logic [SUM_W-1:0] with_grant;
    logic [SUM_W-1:0] rel_ext;
    logic [SUM_W-1:0] next_used;

    assign free_bytes = LEN_W'(BUF_BYTES) - used;
    assign fits       = free_bytes >= need_len;

    // Next occupancy: reservation in, release out, saturating at zero.
    always_comb begin
        with_grant = {1'b0, used} + (grant ? {1'b0, need_len} : '0);
        rel_ext    = release_en ? {1'b0, release_len} : '0;
        next_used  = (rel_ext > with_grant) ? '0 : with_grant - rel_ext;
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (flush) begin
            used <= '0;
        end else begin
            used <= next_used[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/txbid_stream.sv
// Byte stream counter: forwards accepted frame bytes to the buffer, counts them,
// and raises a one-cycle start at the per-frame threshold or on the last byte.
// Assumes ready stays high from the grant through the last byte of the frame.
module txbid_stream #(
    parameter int LEN_W = 12,
    parameter int THR_A = 5,
    parameter int THR_B = 381,
    parameter int THR_C = 1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [7:0]       data_in,
    input  logic             ready,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [1:0]       mode,
    output logic             last_byte,
    output logic             buf_wr_en,
    output logic [7:0]       buf_wr_data,
    output logic             tx_start
);
    logic [LEN_W-1:0] count;
    logic [LEN_W-1:0] next_count;
    logic [LEN_W-1:0] mode_thr;
    logic [LEN_W-1:0] start_at;
    logic             take;

    assign take       = data_wr & ready;
    assign next_count = count + 1'b1;
    assign last_byte  = take && (next_count == frame_len);

    // Threshold for the selected start mode, limited to the frame length.
    always_comb begin
        case (mode)
            2'd0:    mode_thr = LEN_W'(THR_A);
            2'd1:    mode_thr = LEN_W'(THR_B);
            2'd2:    mode_thr = LEN_W'(THR_C);
            default: mode_thr = frame_len;
        endcase
        start_at = (mode_thr > frame_len) ? frame_len : mode_thr;
    end

    // Byte forwarding, counting and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count       <= '0;
            buf_wr_en   <= 1'b0;
            buf_wr_data <= '0;
            tx_start    <= 1'b0;
        end else begin
            buf_wr_en <= take;
            tx_start  <= take && (next_count == start_at);
            if (take) begin
                buf_wr_data <= data_in;
                count       <= last_byte ? '0 : next_count;
            end
        end
    end

endmodule

// File: rtl/txbid_ctrl.sv
// Transmit bid controller top: decodes the register port, joins the bid state machine,
// the space tracker and the byte stream counter, and presents the MAC-side outputs.
// Assumes reg_wr and reg_rd are one-cycle strobes; read data appears one cycle later.
module txbid_ctrl #(
    parameter int REG_W     = 16,
    parameter int BUF_BYTES = 2048,
    parameter int MAX_FRAME = 1514,
    parameter int THR_A     = 5,
    parameter int THR_B     = 381,
    parameter int THR_C     = 1021,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             buf_release,
    input  logic [LEN_W-1:0] buf_release_len,
    output logic             buf_wr_en,
    output logic [7:0]       buf_wr_data,
    output logic             buf_flush,
    output logic             tx_start,
    output logic [LEN_W-1:0] tx_len,
    output logic             tx_no_retry,
    output logic             tx_no_crc,
    output logic             tx_no_pad
);
    import txbid_pkg::*;

    logic             cmd_wr, len_wr, data_wr, stat_rd;
    logic [REG_W-1:0] cmd_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] used;
    logic             st_ready, bid_err, grant, force_req, fits, last_byte;
    logic [REG_W-1:0] stat_word;

    assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
    assign len_wr  = reg_wr && (reg_addr == RA_LEN);
    assign data_wr = reg_wr && (reg_addr == RA_DATA);
    assign stat_rd = reg_rd && (reg_addr == RA_STAT);

    txbid_bid #(
        .REG_W(REG_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)
    ) u_bid (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .len_wr(len_wr),
        .stat_rd(stat_rd), .wdata(reg_wdata), .fits(fits), .last_byte(last_byte),
        .cmd_q(cmd_q), .len_q(len_q), .ready(st_ready), .bid_err(bid_err),
        .grant(grant), .force_req(force_req)
    );

    txbid_space #(
        .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
    ) u_space (
        .clk(clk), .rst_n(rst_n), .grant(grant), .need_len(len_q),
        .release_en(buf_release), .release_len(buf_release_len),
        .flush(force_req), .used(used), .fits(fits)
    );

    txbid_stream #(
        .LEN_W(LEN_W), .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C)
    ) u_stream (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(reg_wdata[7:0]),
        .ready(st_ready), .frame_len(len_q),
        .mode(cmd_q[CMD_MODE_LO+1:CMD_MODE_LO]), .last_byte(last_byte),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .tx_start(tx_start)
    );

    // Status word: ready and bid-error flags at their fixed bit positions.
    always_comb begin
        stat_word           = '0;
        stat_word[STAT_RDY] = st_ready;
        stat_word[STAT_ERR] = bid_err;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                RA_CMD:  reg_rdata <= cmd_q;
                RA_LEN:  reg_rdata <= REG_W'(len_q);
                RA_STAT: reg_rdata <= stat_word;
                default: reg_rdata <= '0;
            endcase
        end
    end

    assign buf_flush   = force_req;
    assign tx_len      = len_q;
    assign tx_no_retry = cmd_q[CMD_ONECOLL];
    assign tx_no_crc   = cmd_q[CMD_NOCRC];
    assign tx_no_pad   = cmd_q[CMD_NOPAD];

endmodule

// File: rtl/txbid_ctrl_chk.sv
// Property checker for the transmit bid controller, bound to the top module.
module txbid_ctrl_chk #(
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic             ready,
    input logic             bid_err,
    input logic             grant,
    input logic [LEN_W-1:0] used,
    input logic             tx_start,
    input logic             buf_wr_en,
    input logic             buf_flush
);
    logic [1:0] starts_seen;

    // Counts start pulses since the last grant.
    always_ff @(posedge clk) begin
        if (!rst_n)        starts_seen <= '0;
        else if (grant)    starts_seen <= '0;
        else if (tx_start && starts_seen != 2'd3) starts_seen <= starts_seen + 1'b1;
    end

    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    p_start_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> starts_seen == 2'd0);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        used <= LEN_W'(BUF_BYTES));

    p_err_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bid_err) |-> !ready);

    p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && !reg_wr) |=> !bid_err);

    p_wr_needs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(ready));

    p_flush_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        buf_flush |=> used == '0);

endmodule

bind txbid_ctrl txbid_ctrl_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .ready(st_ready), .bid_err(bid_err), .grant(grant), .used(used),
    .tx_start(tx_start), .buf_wr_en(buf_wr_en), .buf_flush(buf_flush)
);

// File: tb/txbid_ctrl_bench.sv
// Scoreboard bench: the driver queues each frame's expected start event, and the
// monitor checks every start pulse, byte write and flush against it.
module txbid_ctrl_bench;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          buf_release = 1'b0;
    logic [LW-1:0] buf_release_len = '0;
    logic          buf_wr_en, buf_flush, tx_start;
    logic [7:0]    buf_wr_data;
    logic [LW-1:0] tx_len;
    logic          tx_no_retry, tx_no_crc, tx_no_pad;

    typedef struct {
        int       at_byte;
        int       len;
        logic [2:0] flags;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    int   sent = 0, wr_seen = 0, counted = 0, flush_seen = 0;
    logic [7:0] last_byte_val = '0;
    logic [15:0] rd_val;
    bit   done = 0;

    always #4 clk = ~clk;

    txbid_ctrl u_txbid_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_release(buf_release), .buf_release_len(buf_release_len),
        .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data), .buf_flush(buf_flush),
        .tx_start(tx_start), .tx_len(tx_len), .tx_no_retry(tx_no_retry),
        .tx_no_crc(tx_no_crc), .tx_no_pad(tx_no_pad)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic data_byte(input logic [7:0] b, input bit counts);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = {8'h00, b};
        @(posedge clk);
        if (counts) begin sent++; counted++; end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic release_space(input int n);
        buf_release = 1'b1; buf_release_len = LW'(n);
        @(negedge clk);
        buf_release = 1'b0;
    endtask

    function automatic int exp_thr(input logic [15:0] cmd, input int len);
        int t;
        case (cmd[7:6])
            2'd0: t = 5;
            2'd1: t = 381;
            2'd2: t = 1021;
            default: t = len;
        endcase
        return (t > len) ? len : t;
    endfunction

    // Polls status until ready; returns whether ready was seen.
    task automatic poll_ready(input int tries, output bit seen);
        logic [15:0] v;
        seen = 0;
        for (int i = 0; i < tries && !seen; i++) begin
            rd(2'd2, v);
            if (v[8]) seen = 1;
        end
    endtask

    // Streams a granted frame after queueing its expected start.
    task automatic stream_frame(input logic [15:0] cmd, input int len, input string req);
        exp_t e;
        logic [15:0] v;
        e.at_byte = exp_thr(cmd, len);
        e.len = len;
        e.flags = {cmd[13], cmd[12], cmd[9]};
        exp_q.push_back(e);
        sent = 0;
        for (int i = 0; i < len; i++) data_byte(8'(i + 3), 1'b1);
        @(negedge clk);
        check(exp_q.size() == 0, {req, " start issued"}, exp_q.size(), 0);
        rd(2'd2, v);
        check(v[8] == 1'b0, "R9 ready clears after last byte", int'(v[8]), 0);
    endtask

    task automatic send_frame(input logic [15:0] cmd, input int len, input string req);
        bit seen;
        wr(2'd0, cmd);
        wr(2'd1, 16'(len));
        poll_ready(10, seen);
        check(seen, {req, " ready after bid"}, int'(seen), 1);
        stream_frame(cmd, len, req);
        release_space(len);
    endtask

    // Monitor: scoreboard pop on each start pulse; counts buffer writes and flushes.
    initial begin
        forever begin
            @(negedge clk);
            if (buf_wr_en) begin wr_seen++; last_byte_val = buf_wr_data; end
            if (buf_flush) flush_seen++;
            if (tx_start) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected start", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(sent == e.at_byte, "R7/R8 start byte (R7 R8)", sent, e.at_byte);
                    check(int'(tx_len) == e.len, "R11 tx_len", int'(tx_len), e.len);
                    check({tx_no_pad, tx_no_crc, tx_no_retry} == e.flags, "R11 flags",
                          int'({tx_no_pad, tx_no_crc, tx_no_retry}), int'(e.flags));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check(!tx_start && !buf_wr_en && !buf_flush, "R13 outputs idle", int'(tx_start), 0);
        rd(2'd2, rd_val);
        check(rd_val == 16'h0, "R13 status zero", int'(rd_val), 0);
        rd(2'd0, rd_val);
        check(rd_val == 16'h0, "R13 command zero", int'(rd_val), 0);

        // R1 command read-back
        wr(2'd0, 16'hB2C5);
        rd(2'd0, rd_val);
        check(rd_val == 16'hB2C5, "R1 command readback", int'(rd_val), 16'hB2C5);

        // R7 R11 modes and flags
        send_frame(16'h0000, 60, "R7 mode00");
        send_frame(16'h1240, 400, "R7 mode01");
        send_frame(16'h2080, 1100, "R7 mode10");
        send_frame(16'h00C0, 64, "R7 mode11");
        send_frame(16'h3240, 100, "R8 short frame");
        check(last_byte_val == 8'(99 + 3), "R11 data byte passed", int'(last_byte_val), 102);

        // R3 R4 bad lengths
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd0);
        rd(2'd2, rd_val);
        check(rd_val[7] == 1'b1 && rd_val[8] == 1'b0, "R3 zero length error", int'(rd_val), 16'h0080);
        rd(2'd2, rd_val);
        check(rd_val[7] == 1'b0, "R4 error cleared by read", int'(rd_val[7]), 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd1515);
        rd(2'd2, rd_val);
        check(rd_val[7] == 1'b1, "R3 1515 rejected", int'(rd_val[7]), 1);
        // R2 length without fresh command
        wr(2'd1, 16'd100);
        rd(2'd2, rd_val);
        check(rd_val[7] == 1'b1 && rd_val[8] == 1'b0, "R2 stale length rejected", int'(rd_val), 16'h0080);

        // R6 unsolicited data dropped
        for (int i = 0; i < 3; i++) data_byte(8'hEE, 1'b0);
        @(negedge clk);
        check(wr_seen == counted, "R6 dropped bytes", wr_seen, counted);

        // R5 space wait and release
        wr(2'd0, 16'h00C0);
        wr(2'd1, 16'd1514);
        poll_ready(10, seen);
        check(seen, "R3 1514 accepted", int'(seen), 1);
        stream_frame(16'h00C0, 1514, "R5 full frame");
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd1000);
        poll_ready(20, seen);
        check(!seen, "R5 ready held clear when short of space", int'(seen), 0);
        // R12 writes during pending bid ignored
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'd5);
        rd(2'd0, rd_val);
        check(rd_val == 16'h0000, "R12 command kept", int'(rd_val), 0);
        rd(2'd2, rd_val);
        check(rd_val[7] == 1'b0, "R12 no bid error", int'(rd_val[7]), 0);
        release_space(1514);
        poll_ready(10, seen);
        check(seen, "R5 ready after release", int'(seen), 1);
        stream_frame(16'h0000, 1000, "R5 after release");
        // 1000 bytes remain reserved; fill to leave too little room, then force.
        wr(2'd0, 16'h00C0);
        wr(2'd1, 16'd1000);
        poll_ready(10, seen);
        check(seen, "R5 second 1000 fits", int'(seen), 1);
        stream_frame(16'h00C0, 1000, "R5 second frame");
        flush_seen = 0;
        wr(2'd0, 16'h0100);
        wr(2'd1, 16'd1200);
        poll_ready(10, seen);
        check(flush_seen == 1, "R10 flush pulse", flush_seen, 1);
        check(seen, "R10 space freed by force", int'(seen), 1);
        stream_frame(16'h0100, 1200, "R10 forced frame");
        release_space(1200);

        @(negedge clk);
        check(wr_seen == counted, "R6 buffer writes match accepted bytes", wr_seen, counted);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule